// File: doc/BRIEF.md
# UART Receive Path with Status-Tagged FIFO

This block turns an asynchronous serial input line into a stream of 12-bit entries that software or a downstream engine can read at its own pace. A fractional baud divisor produces a sampling tick sixteen times per bit period. A receive state machine uses that tick to find start bits, discard glitches, and sample the data, parity and stop bits at mid-bit. It also detects a line held low as a break. Framing bits are removed; each stored entry holds the character in bits 7:0 and four condition flags in bits 11:8.

Entries are held in a 32-deep buffer that is read in show-ahead fashion: the head entry is always visible on `rd_data_o`, and `rd_en_i` retires it. Clearing `fifo_en_i` limits the buffer to a single entry, which turns it into a one-character holding register. When no room is left, a newly completed character is dropped and the loss is marked on the most recently stored entry.

Top module: `uart_rx_core`

## Requirements
- R1: The sampling tick period is `div_int_i` reference cycles, plus one extra cycle whenever a 6-bit accumulator that adds `div_frac_i` each tick carries out. The mean period is therefore `div_int_i + div_frac_i/64` cycles, and one bit lasts 16 ticks.
- R2: The line passes through two synchronising flops. Data is taken LSB first, each bit sampled at the middle of its period. Start, parity and stop bits are removed, so the character appears in entry bits 7:0.
- R3: A low pulse that ends before the 8th tick of the start bit is treated as a false start and produces no entry.
- R4: With `par_en_i` high, a parity bit follows the data. If even parity (`par_odd_i`=0) or odd parity (`par_odd_i`=1) is violated, entry bit 9 is set.
- R5: A stop bit sampled low sets entry bit 8 (framing error). The receiver then waits for the line to go high before it accepts a new start.
- R6: A line held low through the whole character, including the parity and stop bits, is a break. It produces a single entry 12'h500 (bit 10 break, bit 8 framing, data zero) and a one-cycle pulse on `break_o`.
- R7: The buffer holds up to 32 entries and returns them in arrival order. `level_o` gives the count, `empty_o` is high at count 0, and `full_o` is high when the count reaches the capacity. The count changes by at most one per cycle.
- R8: When a character completes while the buffer is full, the character is discarded, bit 11 (overrun) is set on the newest stored entry, and the count stays the same.
- R9: With `fifo_en_i` low the capacity is one entry, and the level never exceeds 1.
- R10: `rd_en_i` while the buffer is empty has no effect.
- R11: After reset the buffer is empty, `level_o` is 0, `full_o` is 0 and `break_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial receive line, idle high |
| div_int_i | input | 16 | Integer part of the tick divisor |
| div_frac_i | input | 6 | Fractional part of the tick divisor, in 1/64 |
| par_en_i | input | 1 | A parity bit follows the data |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| fifo_en_i | input | 1 | 1 gives a 32-entry buffer, 0 gives a single entry |
| rd_en_i | input | 1 | Retire the head entry |
| rd_data_o | output | 12 | Head entry: {overrun, break, parity err, framing err, data} |
| empty_o | output | 1 | Buffer empty |
| full_o | output | 1 | Buffer at capacity |
| level_o | output | 6 | Number of stored entries |
| break_o | output | 1 | One-cycle pulse on break detection |

## Verification
A break can complete in the same cycle that the buffer is full. In that cycle two things happen together: break detection and overrun handling. The bench fills the buffer with 32 characters and one extra, then holds the line low for twelve bit times. It then expects a `break_o` pulse, no change in level, and the overrun flag on entry 31 with no break entry behind it. A behavioural queue model predicts the level, the full flag and the head entry, and these are compared on every clock while the line is quiet.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W      = 8;
  localparam int ENTRY_W     = 12;
  localparam int OVR_BIT     = 11;
  localparam logic [ENTRY_W-1:0] BREAK_ENTRY = 12'h500;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAIT
  } rx_state_e;
endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int IW = 16,
  parameter int FW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] div_int_i,
  input  logic [FW-1:0] div_frac_i,
  output logic          tick_o
);
  logic [IW-1:0] cnt_q;
  logic [FW-1:0] acc_q;
  logic          extra_q;
  logic [IW:0]   lim;
  logic [FW:0]   acc_sum;

  assign lim     = {1'b0, div_int_i} - (IW+1)'(1) + (IW+1)'(extra_q);
  assign acc_sum = {1'b0, acc_q} + {1'b0, div_frac_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      extra_q <= 1'b0;
      tick_o  <= 1'b0;
    end else if (div_int_i == '0) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if ({1'b0, cnt_q} >= lim) begin
      cnt_q   <= '0;
      tick_o  <= 1'b1;
      acc_q   <= acc_sum[FW-1:0];
      extra_q <= acc_sum[FW];  // carry stretches the next period
    end else begin
      cnt_q  <= cnt_q + IW'(1);
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 rxd_i,
  input  logic                 par_en_i,
  input  logic                 par_odd_i,
  output logic                 push_o,
  output logic [ENTRY_W-2:0]   entry_o,
  output logic                 brk_o
);
  rx_state_e         state_q;
  logic [1:0]        sync_q;
  logic [3:0]        tcnt_q;
  logic [2:0]        bcnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic              pbit_q;
  logic              rx_s;
  logic              is_brk;
  logic              par_bad;

  assign rx_s    = sync_q[1];
  assign is_brk  = ~rx_s & (shreg_q == '0) & ~(par_en_i & pbit_q);
  assign par_bad = par_en_i & ~is_brk & (^shreg_q ^ pbit_q ^ par_odd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      sync_q  <= 2'b11;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      shreg_q <= '0;
      pbit_q  <= 1'b0;
      push_o  <= 1'b0;
      entry_o <= '0;
      brk_o   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      push_o <= 1'b0;
      brk_o  <= 1'b0;
      unique case (state_q)
        S_IDLE: if (tick_i && !rx_s) begin
          state_q <= S_START;
          tcnt_q  <= '0;
          pbit_q  <= 1'b0;
        end
        S_START: if (tick_i) begin
          if (tcnt_q == 4'd6) begin  // 8th tick of start bit
            tcnt_q  <= '0;
            bcnt_q  <= '0;
            state_q <= rx_s ? S_IDLE : S_DATA;
          end else tcnt_q <= tcnt_q + 4'd1;
        end
        S_DATA: if (tick_i) begin
          if (tcnt_q == 4'd15) begin
            tcnt_q  <= '0;
            shreg_q <= {rx_s, shreg_q[DATA_W-1:1]};
            if (bcnt_q == 3'd7) state_q <= par_en_i ? S_PAR : S_STOP;
            else bcnt_q <= bcnt_q + 3'd1;
          end else tcnt_q <= tcnt_q + 4'd1;
        end
        S_PAR: if (tick_i) begin
          if (tcnt_q == 4'd15) begin
            tcnt_q  <= '0;
            pbit_q  <= rx_s;
            state_q <= S_STOP;
          end else tcnt_q <= tcnt_q + 4'd1;
        end
        S_STOP: if (tick_i) begin
          if (tcnt_q == 4'd15) begin
            tcnt_q  <= '0;
            push_o  <= 1'b1;
            brk_o   <= is_brk;
            entry_o <= {is_brk, par_bad, ~rx_s, shreg_q};
            state_q <= rx_s ? S_IDLE : S_WAIT;
          end else tcnt_q <= tcnt_q + 4'd1;
        end
        S_WAIT: if (rx_s) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LW    = $clog2(DEPTH+1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fifo_en_i,
  input  logic               push_i,
  input  logic [ENTRY_W-1:0] din_i,
  input  logic               rd_en_i,
  output logic [ENTRY_W-1:0] dout_o,
  output logic               empty_o,
  output logic               full_o,
  output logic [LW-1:0]      level_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ENTRY_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]      wr_ptr_q, rd_ptr_q, last_idx;
  logic [LW-1:0]      cnt_q, cap;
  logic               rd_fire, wr_ok, ovr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign cap      = fifo_en_i ? LW'(DEPTH) : LW'(1);
  assign full_o   = (cnt_q >= cap);
  assign empty_o  = (cnt_q == '0);
  assign level_o  = cnt_q;
  assign rd_fire  = rd_en_i & ~empty_o;
  assign wr_ok    = push_i & (~full_o | rd_fire);
  assign ovr      = push_i & ~wr_ok;
  assign last_idx = (wr_ptr_q == '0) ? AW'(DEPTH-1) : wr_ptr_q - AW'(1);
  assign dout_o   = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_ok)   wr_ptr_q <= nxt(wr_ptr_q);
      if (rd_fire) rd_ptr_q <= nxt(rd_ptr_q);
      case ({wr_ok, rd_fire})
        2'b10:   cnt_q <= cnt_q + LW'(1);
        2'b01:   cnt_q <= cnt_q - LW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok)    mem_q[wr_ptr_q]          <= din_i;
    else if (ovr) mem_q[last_idx][OVR_BIT] <= 1'b1;
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DIV_IW = 16,
  parameter int DIV_FW = 6,
  localparam int LW    = $clog2(DEPTH+1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rxd_i,
  input  logic [DIV_IW-1:0]  div_int_i,
  input  logic [DIV_FW-1:0]  div_frac_i,
  input  logic               par_en_i,
  input  logic               par_odd_i,
  input  logic               fifo_en_i,
  input  logic               rd_en_i,
  output logic [ENTRY_W-1:0] rd_data_o,
  output logic               empty_o,
  output logic               full_o,
  output logic [LW-1:0]      level_o,
  output logic               break_o
);
  logic               tick;
  logic               push;
  logic [ENTRY_W-2:0] entry;

  uart_rx_baud #(.IW(DIV_IW), .FW(DIV_FW)) baud_i (
    .clk_i, .rst_ni, .div_int_i, .div_frac_i, .tick_o(tick)
  );

  uart_rx_fsm fsm_i (
    .clk_i, .rst_ni, .tick_i(tick), .rxd_i, .par_en_i, .par_odd_i,
    .push_o(push), .entry_o(entry), .brk_o(break_o)
  );

  uart_rx_fifo #(.DEPTH(DEPTH), .LW(LW)) fifo_i (
    .clk_i, .rst_ni, .fifo_en_i, .push_i(push), .din_i({1'b0, entry}),
    .rd_en_i, .dout_o(rd_data_o), .empty_o, .full_o, .level_o
  );
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LW    = $clog2(DEPTH+1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               fifo_en_i,
  input logic               rd_en_i,
  input logic [ENTRY_W-1:0] rd_data_o,
  input logic               empty_o,
  input logic               full_o,
  input logic [LW-1:0]      level_o,
  input logic               break_o
);
  p_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LW'(DEPTH));

  p_level_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (level_o <= $past(level_o) + LW'(1)) && (level_o + LW'(1) >= $past(level_o)));

  p_full_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !rd_en_i) |=> level_o == $past(level_o));

  p_single_cap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |-> level_o <= LW'(1));

  p_read_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_en_i) |=> level_o <= LW'(1));

  p_break_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (break_o && empty_o) |=> rd_data_o == BREAK_ENTRY);
endmodule

bind uart_rx_core uart_rx_core_chk #(.DEPTH(DEPTH), .LW(LW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .fifo_en_i(fifo_en_i), .rd_en_i(rd_en_i),
  .rd_data_o(rd_data_o), .empty_o(empty_o), .full_o(full_o),
  .level_o(level_o), .break_o(break_o)
);

// File: tb/uart_rx_core_tb_top.sv
module uart_rx_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd = 1'b1;
  logic [15:0] div_int;
  logic [5:0]  div_frac;
  logic        par_en = 1'b0, par_odd = 1'b0, fifo_en = 1'b1, rd_en = 1'b0;
  logic [11:0] rd_data;
  logic        empty, full, brk;
  logic [5:0]  level;

  int checks = 0, fails = 0, brk_cnt = 0;
  bit quiet = 1'b0, done = 1'b0;
  logic [11:0] exp_q[$];

  always #4 clk = ~clk;  // 125 MHz

  uart_rx_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .div_int_i(div_int),
    .div_frac_i(div_frac), .par_en_i(par_en), .par_odd_i(par_odd),
    .fifo_en_i(fifo_en), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .empty_o(empty), .full_o(full), .level_o(level), .break_o(brk)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int cap_now();
    return fifo_en ? 32 : 1;
  endfunction

  // per-clock comparison against the queue model while the line is quiet
  always @(negedge clk) begin
    if (brk) brk_cnt++;
    if (quiet && rst_n) begin
      chk("R7 level", 32'(level), 32'(exp_q.size()));
      chk("R7 full", 32'(full), 32'(exp_q.size() >= cap_now()));
      chk("R7 empty", 32'(empty), 32'(exp_q.size() == 0));
      if (exp_q.size() > 0) chk("R7 head", 32'(rd_data), 32'(exp_q[0]));
    end
  end

  task automatic model_push(input logic [11:0] e);
    logic [11:0] t;
    if (exp_q.size() < cap_now()) exp_q.push_back(e);
    else begin
      t = exp_q[exp_q.size()-1];
      t[11] = 1'b1;
      exp_q[exp_q.size()-1] = t;
    end
  endtask

  function automatic int bit_cyc();
    return (16 * (64 * int'(div_int) + int'(div_frac))) / 64;
  endfunction

  task automatic send_raw(input logic [15:0] bits, input int nb);
    int prev = 0;
    quiet = 1'b0;
    for (int k = 0; k < nb; k++) begin
      int e;
      e = ((k + 1) * 16 * (64 * int'(div_int) + int'(div_frac))) / 64;
      rxd = bits[k];
      repeat (e - prev) @(negedge clk);
      prev = e;
    end
    rxd = 1'b1;
    repeat (2 * bit_cyc()) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input bit bad_par, input bit stop);
    logic [15:0] bits;
    logic        p;
    int          nb;
    logic [11:0] e;
    p = par_odd ? ~^d : ^d;
    if (bad_par) p = ~p;
    bits = '0;
    bits[8:1] = d;
    if (par_en) begin bits[9] = p; bits[10] = stop; nb = 11; end
    else begin bits[9] = stop; nb = 10; end
    send_raw(bits, nb);
    e = {1'b0, 1'b0, par_en & bad_par, ~stop, d};
    model_push(e);
    quiet = 1'b1;
  endtask

  task automatic send_break();
    quiet = 1'b0;
    rxd = 1'b0;
    repeat (12 * bit_cyc()) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * bit_cyc()) @(negedge clk);
    model_push(12'h500);
    quiet = 1'b1;
  endtask

  task automatic pop_check(input string tag);
    @(negedge clk);
    chk(tag, 32'(rd_data), 32'(exp_q[0]));
    rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
    void'(exp_q.pop_front());
  endtask

  task automatic drain(input string tag);
    while (exp_q.size() > 0) pop_check(tag);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int b0;
    div_int = 16'd4; div_frac = 6'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 level", 32'(level), 0);
    chk("R11 empty", 32'(empty), 1);
    chk("R11 full", 32'(full), 0);
    chk("R11 break", 32'(brk), 0);
    quiet = 1'b1;

    // R2 plain framing, LSB first, integer divisor (R1)
    send_char(8'h55, 0, 1);
    send_char(8'hA3, 0, 1);
    send_char(8'h01, 0, 1);
    chk("R2 three stored", 32'(level), 3);
    drain("R2 data");

    // R4 parity even/odd
    par_en = 1'b1; par_odd = 1'b0;
    send_char(8'h37, 0, 1);
    send_char(8'h37, 1, 1);
    par_odd = 1'b1;
    send_char(8'hC4, 0, 1);
    send_char(8'hC4, 1, 1);
    drain("R4 parity");
    par_en = 1'b0; par_odd = 1'b0;

    // R5 framing error then recovery
    send_char(8'h3C, 0, 0);
    send_char(8'h5A, 0, 1);
    pop_check("R5 framing flag");
    pop_check("R5 next char clean");

    // R3 false start: low for 3 ticks only
    quiet = 1'b0;
    rxd = 1'b0;
    repeat (3 * int'(div_int)) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * bit_cyc()) @(negedge clk);
    quiet = 1'b1;
    chk("R3 no entry after false start", 32'(level), 0);
    send_char(8'h96, 0, 1);
    pop_check("R3 char after false start");

    // R6 break
    b0 = brk_cnt;
    send_break();
    chk("R6 break pulse", 32'(brk_cnt - b0), 1);
    pop_check("R6 break entry");

    // R1 fractional divisors
    div_int = 16'd3; div_frac = 6'd32;
    send_char(8'hE1, 0, 1);
    send_char(8'h0F, 0, 1);
    div_int = 16'd2; div_frac = 6'd13;
    send_char(8'hB2, 0, 1);
    par_en = 1'b1;
    send_char(8'h7E, 0, 1);
    par_en = 1'b0;
    drain("R1 fractional");

    // R10 read while empty
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk);
    chk("R10 level stays 0", 32'(level), 0);
    chk("R10 empty stays", 32'(empty), 1);
    send_char(8'h44, 0, 1);
    pop_check("R10 order intact");

    // R7/R8 fill, overrun, then break while full
    div_int = 16'd1; div_frac = 6'd0;
    for (int i = 0; i < 33; i++) send_char(8'(i + 16), 0, 1);
    chk("R8 full", 32'(full), 1);
    chk("R8 level held", 32'(level), 32);
    b0 = brk_cnt;
    send_break();
    chk("R6 break pulse while full", 32'(brk_cnt - b0), 1);
    chk("R8 level after break overrun", 32'(level), 32);
    drain("R7 R8 ordered drain");

    // R9 single-entry mode
    fifo_en = 1'b0;
    send_char(8'h11, 0, 1);
    chk("R9 single full", 32'(full), 1);
    send_char(8'h22, 0, 1);
    chk("R9 level capped", 32'(level), 1);
    pop_check("R9 holding entry with overrun");
    fifo_en = 1'b1;

    repeat (10) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule